// File: doc/BRIEF.md
# Translation Lookaside Buffer with Miss Fill

This block is a small, fully associative store of page-to-frame mappings that sits between an address requester and a page table walker. The requester presents a virtual address on the lookup port. The block compares the page number against every stored mapping in parallel. On a match it returns the physical address in the same cycle, formed from the stored frame number and the untouched page offset.

When no entry matches, the block accepts the lookup and stalls. It drops lookup ready and asks the walker for the missing page. When the walker answers, the block installs the page/frame pair into an entry and completes the translation in that same answer cycle. A walker answer marked as a fault is passed back to the requester and installs nothing. A flush input empties the whole store at once.

Top module: `tlb_fill`

## Requirements
- R1: When lookup ready is high and a lookup is presented whose page number (upper 20 address bits) matches a valid entry, the response is valid in the same cycle with physical address {stored frame, low 12 address bits} and the fault flag low.
- R2: A lookup accepted without a match produces no response in that cycle. From the next cycle the walk request is high, carrying the missed page number, and it holds that page number until the walker answers.
- R3: While a walk is outstanding, lookup ready is low and the lookup valid and address inputs are ignored. The later response uses the offset captured when the lookup was accepted.
- R4: A walker answer without fault produces a valid response in the answer cycle, with address {answered frame, captured offset} and the fault flag low. It installs the mapping, so that a later lookup of that page hits without a walk.
- R5: A walker answer with the fault flag set produces a valid response with the fault flag high and installs nothing, so that a later lookup of that page misses again.
- R6: An installing fill writes the lowest-numbered invalid entry whenever one exists.
- R7: When all 8 entries are valid, a fill replaces the entry chosen by a round-robin pointer. The pointer is 0 after reset and advances by one, modulo 8, on every installing fill, whichever entry that fill wrote.
- R8: A flush invalidates every entry within one cycle, so a lookup in the next cycle misses. A flush in the same cycle as a walker answer blocks that install and leaves the pointer unchanged; the response is still given.
- R9: After reset, lookup ready is high, the walk request and response are low, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_valid_i | input | 1 | Lookup request present |
| lk_vaddr_i | input | 32 | Virtual address: page number in the upper 20 bits, offset in the lower 12 bits |
| lk_ready_o | output | 1 | Block can accept a lookup |
| rsp_valid_o | output | 1 | Translation result present |
| rsp_paddr_o | output | 32 | Physical address: frame number in the upper bits, offset in the lower bits |
| rsp_fault_o | output | 1 | Translation failed at the walker |
| walk_req_o | output | 1 | Walk request outstanding |
| walk_vpn_o | output | 20 | Page number to walk |
| fill_valid_i | input | 1 | Walker answer present |
| fill_pfn_i | input | 20 | Frame number from the walker |
| fill_fault_i | input | 1 | Walker reports a fault |

## Verification
Directed sequences first separate a miss from a following hit on the same page. They then show that a faulting answer leaves that page missing, and that a flush, with or without a coincident answer, turns earlier hits into misses. A fill of nine pages, before and after a flush, separates the policy of taking the lowest free entry from the round-robin pointer, because the page evicted by the ninth fill differs between the two. Random lookups over a page set larger than the store, with random walker latency, faults and occasional flushes, mix hits and evictions. Junk is driven on the lookup inputs during every stall, so an offset or page taken from the wrong cycle shows in the response.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } tlb_state_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_i,
    input  logic [ENTRIES-1:0][PFN_W-1:0] pfn_i,
    input  logic [VPN_W-1:0]              key_i,
    output logic [ENTRIES-1:0]            hit_vec_o,
    output logic                          hit_o,
    output logic [PFN_W-1:0]              pfn_o
);

    // one comparator per entry, all in parallel
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        assign hit_vec_o[gi] = valid_i[gi] && (vpn_i[gi] == key_i);
    end

    assign hit_o = |hit_vec_o;

    // at most one entry matches, so an OR of gated frames is the selected frame
    always_comb begin
        pfn_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec_o[i]) begin
                pfn_o = pfn_o | pfn_i[i];
            end
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [IDX_W-1:0]   rr_i,
    output logic [IDX_W-1:0]   idx_o
);

    // lowest free slot wins; round-robin pointer only when none is free
    always_comb begin
        idx_o = rr_i;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_fill.sv
module tlb_fill
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int OFF_W   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush_i,
    input  logic                   lk_valid_i,
    input  logic [VPN_W+OFF_W-1:0] lk_vaddr_i,
    output logic                   lk_ready_o,
    output logic                   rsp_valid_o,
    output logic [PFN_W+OFF_W-1:0] rsp_paddr_o,
    output logic                   rsp_fault_o,
    output logic                   walk_req_o,
    output logic [VPN_W-1:0]       walk_vpn_o,
    input  logic                   fill_valid_i,
    input  logic [PFN_W-1:0]       fill_pfn_i,
    input  logic                   fill_fault_i
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] RR_LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        tlb_state_e                   state;
        logic [ENTRIES-1:0]           valid;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PFN_W-1:0] pfn;
        logic [IDX_W-1:0]             rr;
        logic [VPN_W-1:0]             lat_vpn;
        logic [OFF_W-1:0]             lat_off;
    } regs_t;

    regs_t r_d, r_q;

    logic [VPN_W-1:0]   key_vpn;
    logic [OFF_W-1:0]   key_off;
    logic [ENTRIES-1:0] hit_vec;
    logic               hit;
    logic [PFN_W-1:0]   hit_pfn;
    logic [IDX_W-1:0]   victim;
    logic               walking;
    logic               accept;
    logic               answer;

    assign key_vpn = lk_vaddr_i[VPN_W+OFF_W-1:OFF_W];
    assign key_off = lk_vaddr_i[OFF_W-1:0];

    tlb_match #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W)
    ) u_match (
        .valid_i   (r_q.valid),
        .vpn_i     (r_q.vpn),
        .pfn_i     (r_q.pfn),
        .key_i     (key_vpn),
        .hit_vec_o (hit_vec),
        .hit_o     (hit),
        .pfn_o     (hit_pfn)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_victim (
        .valid_i (r_q.valid),
        .rr_i    (r_q.rr),
        .idx_o   (victim)
    );

    assign walking = (r_q.state == ST_WALK);
    assign accept  = lk_valid_i && !walking;
    assign answer  = walking && fill_valid_i;

    always_comb begin
        r_d = r_q;

        if (accept && !hit) begin
            r_d.state   = ST_WALK;
            r_d.lat_vpn = key_vpn;
            r_d.lat_off = key_off;
        end

        if (answer) begin
            r_d.state = ST_IDLE;
            if (!fill_fault_i && !flush_i) begin
                r_d.valid[victim] = 1'b1;
                r_d.vpn[victim]   = r_q.lat_vpn;
                r_d.pfn[victim]   = fill_pfn_i;
                r_d.rr            = (r_q.rr == RR_LAST) ? '0 : r_q.rr + 1'b1;
            end
        end

        if (flush_i) begin
            r_d.valid = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign lk_ready_o  = !walking;
    assign walk_req_o  = walking;
    assign walk_vpn_o  = r_q.lat_vpn;
    assign rsp_valid_o = (accept && hit) || answer;
    assign rsp_fault_o = answer && fill_fault_i;
    assign rsp_paddr_o = walking ? {fill_pfn_i, r_q.lat_off} : {hit_pfn, key_off};

    // parallel compare never finds the same page twice
    assert_onehot_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_hit_answers_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid_i && lk_ready_o && hit) |-> (rsp_valid_o && !rsp_fault_o));

    assert_miss_walks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid_i && lk_ready_o && !rsp_valid_o) |=> (walk_req_o && !lk_ready_o));

    assert_walk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_o && !fill_valid_i) |=> (walk_req_o && $stable(walk_vpn_o)));

    assert_fill_installs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_o && fill_valid_i && !fill_fault_i && !flush_i) |=>
        ($countones(r_q.valid) ==
         $past($countones(r_q.valid)) + ($past(&r_q.valid) ? 0 : 1)));

    assert_fault_no_install_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_o && fill_valid_i && fill_fault_i && !flush_i) |=>
        ($stable(r_q.valid) && $stable(r_q.rr)));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (r_q.valid == '0));

endmodule

// File: tb/tlb_fill_tb.sv
`timescale 1ns/1ps
module tlb_fill_tb;

    localparam int E = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        lk_valid_i = 1'b0;
    logic [31:0] lk_vaddr_i = '0;
    logic        lk_ready_o;
    logic        rsp_valid_o;
    logic [31:0] rsp_paddr_o;
    logic        rsp_fault_o;
    logic        walk_req_o;
    logic [19:0] walk_vpn_o;
    logic        fill_valid_i = 1'b0;
    logic [19:0] fill_pfn_i = '0;
    logic        fill_fault_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference contents kept from the requirements
    bit        m_valid [E];
    logic [19:0] m_vpn [E];
    logic [19:0] m_pfn [E];
    int        m_rr = 0;

    always #2 clk = ~clk;

    tlb_fill u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .lk_valid_i   (lk_valid_i),
        .lk_vaddr_i   (lk_vaddr_i),
        .lk_ready_o   (lk_ready_o),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_paddr_o  (rsp_paddr_o),
        .rsp_fault_o  (rsp_fault_o),
        .walk_req_o   (walk_req_o),
        .walk_vpn_o   (walk_vpn_o),
        .fill_valid_i (fill_valid_i),
        .fill_pfn_i   (fill_pfn_i),
        .fill_fault_i (fill_fault_i)
    );

    function automatic logic [19:0] frame_of(input logic [19:0] vpn);
        return (vpn * 20'd37) ^ 20'h5A3C1;
    endfunction

    function automatic bit model_hit(input logic [19:0] vpn, output logic [19:0] pfn);
        pfn = '0;
        for (int i = 0; i < E; i++) begin
            if (m_valid[i] && m_vpn[i] == vpn) begin
                pfn = m_pfn[i];
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    function automatic int model_victim();
        for (int i = 0; i < E; i++) begin
            if (!m_valid[i]) return i;
        end
        return m_rr;
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < E; i++) m_valid[i] = 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one lookup; on a miss acts as the walker with the given latency
    task automatic do_lookup(input logic [19:0] vpn, input logic [11:0] off, input int dly,
                             input bit flt, input bit fl_fill, input string tag);
        logic [19:0] epfn;
        bit          ehit;
        int          vi;
        ehit = model_hit(vpn, epfn);
        @(negedge clk);
        lk_valid_i = 1'b1;
        lk_vaddr_i = {vpn, off};
        #1;
        chk(lk_ready_o == 1'b1, {tag, " R3 ready idle"}, 64'(lk_ready_o), 64'd1);
        if (ehit) begin
            chk(rsp_valid_o && !rsp_fault_o && rsp_paddr_o == {epfn, off},
                {tag, " R1 hit"}, {31'd0, rsp_valid_o, rsp_paddr_o}, {31'd0, 1'b1, epfn, off});
            @(negedge clk);
            lk_valid_i = 1'b0;
        end else begin
            chk(rsp_valid_o == 1'b0, {tag, " R2 miss no rsp"}, 64'(rsp_valid_o), 64'd0);
            @(negedge clk);
            lk_vaddr_i = $urandom;
            for (int k = 0; k < dly; k++) begin
                #1;
                chk(walk_req_o && walk_vpn_o == vpn && !lk_ready_o && !rsp_valid_o,
                    {tag, " R3 stall"}, {walk_req_o, lk_ready_o, rsp_valid_o, 41'd0, walk_vpn_o},
                    {1'b1, 1'b0, 1'b0, 41'd0, vpn});
                @(negedge clk);
                lk_vaddr_i = $urandom;
            end
            lk_valid_i   = 1'b0;
            fill_valid_i = 1'b1;
            fill_pfn_i   = frame_of(vpn);
            fill_fault_i = flt;
            flush_i      = fl_fill;
            #1;
            chk(walk_req_o && walk_vpn_o == vpn, {tag, " R2 walk page"},
                {43'd0, walk_req_o, walk_vpn_o}, {43'd0, 1'b1, vpn});
            chk(rsp_valid_o && rsp_fault_o == flt && rsp_paddr_o == {frame_of(vpn), off},
                flt ? {tag, " R5 fault rsp"} : {tag, " R4 fill rsp"},
                {30'd0, rsp_valid_o, rsp_fault_o, rsp_paddr_o},
                {30'd0, 1'b1, flt, frame_of(vpn), off});
            @(negedge clk);
            fill_valid_i = 1'b0;
            fill_fault_i = 1'b0;
            flush_i      = 1'b0;
            if (fl_fill) begin
                model_clear();
            end else if (!flt) begin
                vi = model_victim();
                m_valid[vi] = 1'b1;
                m_vpn[vi]   = vpn;
                m_pfn[vi]   = frame_of(vpn);
                m_rr        = (m_rr + 1) % E;
            end
        end
    endtask

    task automatic flush_pulse();
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        model_clear();
    endtask

    // lookup whose hit or miss is stated explicitly by the test
    task automatic expect_state(input logic [19:0] vpn, input bit exp_hit, input string tag);
        logic [19:0] p;
        bit          mh;
        mh = model_hit(vpn, p);
        chk(mh == exp_hit, {tag, " reference"}, 64'(mh), 64'(exp_hit));
        do_lookup(vpn, 12'h3C4, 1, 1'b0, 1'b0, tag);
    endtask

    initial begin
        void'($urandom(32'd2718));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(lk_ready_o == 1'b1, "R9 ready", 64'(lk_ready_o), 64'd1);
        chk(walk_req_o == 1'b0, "R9 walk", 64'(walk_req_o), 64'd0);
        chk(rsp_valid_o == 1'b0, "R9 rsp", 64'(rsp_valid_o), 64'd0);

        // empty store: first lookup must miss, then hit with new offset
        expect_state(20'h12345, 1'b0, "R9 empty");
        do_lookup(20'h12345, 12'hABC, 0, 1'b0, 1'b0, "R4 rehit");

        // faulting answer installs nothing
        do_lookup(20'h00777, 12'h010, 2, 1'b1, 1'b0, "R5 fault");
        expect_state(20'h00777, 1'b0, "R5 retry");

        // flush empties, flush with fill blocks install
        flush_pulse();
        expect_state(20'h12345, 1'b0, "R8 after flush");
        do_lookup(20'h0BEEF, 12'h001, 1, 1'b0, 1'b1, "R8 flush fill");
        expect_state(20'h0BEEF, 1'b0, "R8 blocked");

        // replacement: clean start, 8 fills, 9th evicts round-robin slot
        flush_pulse();
        for (int p = 0; p < 8; p++) do_lookup(20'h00100 + 20'(p), 12'h000, 0, 1'b0, 1'b0, "R6 fill");
        for (int p = 0; p < 8; p++) expect_state(20'h00100 + 20'(p), 1'b1, "R6 present");
        do_lookup(20'h00200, 12'h000, 0, 1'b0, 1'b0, "R7 evict");
        // free slots were taken in index order; the pointer then selects by its count
        for (int p = 0; p < 8; p++) begin
            logic [19:0] q;
            bit alive;
            alive = model_hit(20'h00100 + 20'(p), q);
            expect_state(20'h00100 + 20'(p), alive, "R7 victim");
        end

        // second round after flush: free slots used in order, not the pointer
        flush_pulse();
        for (int p = 0; p < 8; p++) do_lookup(20'h00300 + 20'(p), 12'h000, 0, 1'b0, 1'b0, "R6 refill");
        do_lookup(20'h00400, 12'h000, 0, 1'b0, 1'b0, "R7 evict2");
        for (int p = 0; p < 8; p++) begin
            logic [19:0] q;
            bit alive;
            alive = model_hit(20'h00300 + 20'(p), q);
            expect_state(20'h00300 + 20'(p), alive, "R6 order");
        end

        // random mix
        for (int it = 0; it < 500; it++) begin
            logic [19:0] v;
            v = 20'h04000 + 20'($urandom % 12);
            if ($urandom % 40 == 0) flush_pulse();
            do_lookup(v, 12'($urandom), int'($urandom % 4), ($urandom % 8) == 0,
                      ($urandom % 50) == 0, "R1 R4 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule